// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This block sits beside a CPU's fetch stage and decides, for every fetch address presented to it, whether the core should stop. It keeps a small table of regular breakpoints, one per address. Each carries an enable, a log flag and a break flag. An outside condition evaluator supplies one condition-true bit per table slot, and a hit needs that bit. A regular hit with the log flag raises a one-cycle log strobe that carries the address and slot. A hit with the break flag raises the halt request. An entry with only the log flag records the event and lets the core run on.

Beside the table sits one temporary breakpoint register. Debug software uses it for step-over and run-to-address. A step-over of a branch-and-link instruction arms it four bytes past that instruction. When it matches, it halts the core even if a regular entry holds the same address. That regular entry is left untouched in the table. The temporary breakpoint disarms itself as soon as the core enters the halted state, whatever caused that halt, so a stale one never fires after a later resume.

Host writes use a valid/ready handshake. `bp_wr_ready` is high whenever the written address is already in the table or a free slot exists. It drops only when the address is new and every slot is occupied; a write offered then waits and changes nothing. Clearing, arming and the fetch-address input are plain strobes that are never held off.

Top module: `bp_unit`

## Requirements
- R1: The table holds at most one valid entry per address. An accepted write to an address already present updates that entry's flags in place. An accepted write to a new address fills the lowest-numbered free slot. `bp_wr_ready` is low only when the address is absent and all slots are valid.
- R2: A regular entry in slot i matches only in a cycle where `fetch_valid` is high, `halted` is low, the entry is valid, its address equals `fetch_pc`, its enable flag is set and `cond_true[i]` is high.
- R3: A regular match with the log flag set pulses `log_stb` for one cycle, one cycle after the fetch address was presented. In that cycle `log_addr` holds the fetch address and `log_idx` holds the slot number. A match with the log flag set and the break flag clear never raises `halt_req`.
- R4: `halt_req` is registered and is high in the cycle after a presenting cycle that matched a breakpoint with break behaviour. While `halted` is high, no match is evaluated and neither `halt_req` nor `log_stb` rises.
- R5: A pulse on `tmp_arm` arms the temporary breakpoint at `tmp_base`, or at `tmp_base` + 4 when `tmp_plus4` is high. Arming replaces any previously armed address. `tmp_armed` reflects the armed state from the next cycle.
- R6: When the armed temporary address equals the presented fetch address, `halt_req` rises in the next cycle regardless of the table. A regular entry at the same address produces no log strobe in that cycle. That entry remains in the table and matches again once the temporary breakpoint is gone.
- R7: The temporary breakpoint disarms on the clock edge where `halted` is first seen high after being low. If `tmp_arm` is pulsed in that same cycle, the new arm wins.
- R8: A pulse on `clr_valid` invalidates the entry whose address equals `clr_addr`; an absent address leaves the table unchanged. If a write and a clear of the same address coincide, the write wins.
- R9: After reset the table is empty, the temporary breakpoint is disarmed, `halt_req` and `log_stb` are low and `bp_wr_ready` is high.
- R10: Matching in a cycle uses the table and temporary register as they stood before that cycle's write, clear or arm takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_pc | input | AW | Fetch address under test |
| cond_true | input | N | Per-slot condition result from the evaluator |
| halted | input | 1 | Core is currently halted |
| bp_wr_valid | input | 1 | Host offers a table write |
| bp_wr_ready | output | 1 | Table can accept the offered write |
| bp_wr_addr | input | AW | Address of the written entry |
| bp_wr_en | input | 1 | Enable flag for the written entry |
| bp_wr_log | input | 1 | Log flag for the written entry |
| bp_wr_brk | input | 1 | Break flag for the written entry |
| clr_valid | input | 1 | Remove the entry at `clr_addr` |
| clr_addr | input | AW | Address to remove |
| tmp_arm | input | 1 | Arm the temporary breakpoint |
| tmp_base | input | AW | Base address for arming |
| tmp_plus4 | input | 1 | Arm at base + 4 (step over a linking branch) |
| halt_req | output | 1 | Registered request to halt the core |
| log_stb | output | 1 | One-cycle log event |
| log_addr | output | AW | Address of the logged hit |
| log_idx | output | IW | Slot of the logged hit |
| tmp_armed | output | 1 | Temporary breakpoint is armed |

## Verification
The bound checker watches, on every cycle, that no two valid slots share an address. It also checks that halt and log pulses only follow a cycle that presented an address while running, and that an armed temporary match always produces a halt. Arming always leaves the register armed, and entering the halted state always disarms it. Some behaviour shows only in the bench's scenarios against its reference model. That covers slot allocation order, in-place update and full-table back-pressure. It also covers log-only entries, the suppressed log under a temporary match, and the regular entry surviving that match. Clear-versus-write ordering and matching against the pre-write table are shown the same way.

// File: rtl/bp_pkg.sv
package bp_pkg;
  parameter int unsigned BP_ADDR_W  = 32;
  parameter int unsigned BP_ENTRIES = 8;
  parameter int unsigned BP_STEP    = 4;

  typedef struct packed {
    logic en;
    logic lg;
    logic brk;
  } bp_flags_t;
endpackage

// File: rtl/bp_match.sv
// Parallel address compare over a set of slots, lowest index reported.
module bp_match #(
  parameter int unsigned AW = 32,
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [AW-1:0]         key,
  input  logic [N-1:0]          vld,
  input  logic [N-1:0][AW-1:0]  addrs,
  output logic                  hit,
  output logic [IW-1:0]         idx
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = vld[g] && (addrs[g] == key);
  end

  always_comb begin
    hit = |eq;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/bp_table.sv
// Regular breakpoint storage: unique addresses, in-place update, clear by address.
module bp_table
  import bp_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [AW-1:0]         wr_addr,
  input  bp_flags_t             wr_flags,
  input  logic                  clr_valid,
  input  logic [AW-1:0]         clr_addr,
  output logic [N-1:0]          ent_vld,
  output logic [N-1:0][AW-1:0]  ent_addr,
  output bp_flags_t [N-1:0]     ent_flags
);
  logic [N-1:0]          vld_q;
  logic [N-1:0][AW-1:0]  addr_q;
  bp_flags_t [N-1:0]     flags_q;

  logic          wr_hit, clr_hit, free_any, wr_go;
  logic [IW-1:0] wr_idx, clr_idx, free_idx, wr_slot;

  bp_match #(.AW(AW), .N(N), .IW(IW)) u_wmatch (
    .key(wr_addr), .vld(vld_q), .addrs(addr_q), .hit(wr_hit), .idx(wr_idx)
  );

  bp_match #(.AW(AW), .N(N), .IW(IW)) u_cmatch (
    .key(clr_addr), .vld(vld_q), .addrs(addr_q), .hit(clr_hit), .idx(clr_idx)
  );

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_any = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  assign wr_ready = wr_hit | free_any;
  assign wr_go    = wr_valid & wr_ready;
  assign wr_slot  = wr_hit ? wr_idx : free_idx;

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[g]   <= 1'b0;
        addr_q[g]  <= '0;
        flags_q[g] <= '0;
      end else if (wr_go && (wr_slot == IW'(g))) begin
        vld_q[g]   <= 1'b1;
        addr_q[g]  <= wr_addr;
        flags_q[g] <= wr_flags;
      end else if (clr_valid && clr_hit && (clr_idx == IW'(g))) begin
        vld_q[g]   <= 1'b0;
      end
    end
  end

  assign ent_vld   = vld_q;
  assign ent_addr  = addr_q;
  assign ent_flags = flags_q;
endmodule

// File: rtl/bp_tmp.sv
// Single one-shot temporary breakpoint, disarmed on entry to the halted state.
module bp_tmp
  import bp_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = BP_STEP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [AW-1:0] base,
  input  logic          plus4,
  input  logic          halted,
  output logic          armed,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic          halted_q, armed_q, enter;
  logic [AW-1:0] addr_q, addr_n;

  assign enter  = halted & ~halted_q;
  assign addr_n = base + (plus4 ? STEP_V : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      armed_q  <= 1'b0;
      addr_q   <= '0;
    end else begin
      halted_q <= halted;
      if (arm) begin
        armed_q <= 1'b1;
        addr_q  <= addr_n;
      end else if (enter) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign armed = armed_q;
  assign addr  = addr_q;
endmodule

// File: rtl/bp_unit.sv
module bp_unit
  import bp_pkg::*;
#(
  parameter int unsigned AW = BP_ADDR_W,
  parameter int unsigned N  = BP_ENTRIES,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic [N-1:0]  cond_true,
  input  logic          halted,
  input  logic          bp_wr_valid,
  output logic          bp_wr_ready,
  input  logic [AW-1:0] bp_wr_addr,
  input  logic          bp_wr_en,
  input  logic          bp_wr_log,
  input  logic          bp_wr_brk,
  input  logic          clr_valid,
  input  logic [AW-1:0] clr_addr,
  input  logic          tmp_arm,
  input  logic [AW-1:0] tmp_base,
  input  logic          tmp_plus4,
  output logic          halt_req,
  output logic          log_stb,
  output logic [AW-1:0] log_addr,
  output logic [IW-1:0] log_idx,
  output logic          tmp_armed
);
  logic [N-1:0]          ent_vld;
  logic [N-1:0][AW-1:0]  ent_addr;
  bp_flags_t [N-1:0]     ent_flags;
  bp_flags_t             wr_flags;
  logic [AW-1:0]         tmp_addr;
  logic [N-1:0]          live;
  logic                  reg_hit, eval, tmp_hit, halt_d, log_d;
  logic [IW-1:0]         reg_idx;
  bp_flags_t             sel_flags;

  assign wr_flags = '{en: bp_wr_en, lg: bp_wr_log, brk: bp_wr_brk};

  bp_table #(.AW(AW), .N(N), .IW(IW)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(bp_wr_valid), .wr_ready(bp_wr_ready), .wr_addr(bp_wr_addr), .wr_flags(wr_flags),
    .clr_valid(clr_valid), .clr_addr(clr_addr),
    .ent_vld(ent_vld), .ent_addr(ent_addr), .ent_flags(ent_flags)
  );

  bp_tmp #(.AW(AW)) u_tmp (
    .clk(clk), .rst_n(rst_n), .arm(tmp_arm), .base(tmp_base), .plus4(tmp_plus4),
    .halted(halted), .armed(tmp_armed), .addr(tmp_addr)
  );

  for (genvar g = 0; g < N; g++) begin : g_live
    assign live[g] = ent_vld[g] & ent_flags[g].en & cond_true[g];
  end

  bp_match #(.AW(AW), .N(N), .IW(IW)) u_look (
    .key(fetch_pc), .vld(live), .addrs(ent_addr), .hit(reg_hit), .idx(reg_idx)
  );

  always_comb begin
    sel_flags = ent_flags[reg_idx];
    eval      = fetch_valid & ~halted;
    tmp_hit   = eval & tmp_armed & (fetch_pc == tmp_addr);
    halt_d    = tmp_hit | (eval & reg_hit & sel_flags.brk);
    log_d     = eval & ~tmp_hit & reg_hit & sel_flags.lg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_req <= 1'b0;
      log_stb  <= 1'b0;
      log_addr <= '0;
      log_idx  <= '0;
    end else begin
      halt_req <= halt_d;
      log_stb  <= log_d;
      if (log_d) begin
        log_addr <= fetch_pc;
        log_idx  <= reg_idx;
      end
    end
  end
endmodule

// File: rtl/bp_unit_chk.sv
module bp_unit_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned N  = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fetch_valid,
  input logic [AW-1:0]        fetch_pc,
  input logic                 halted,
  input logic                 tmp_arm,
  input logic                 tmp_armed,
  input logic [AW-1:0]        tmp_addr,
  input logic                 halt_req,
  input logic                 log_stb,
  input logic [N-1:0]         ent_vld,
  input logic [N-1:0][AW-1:0] ent_addr
);
  logic dup;

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (ent_vld[i] && ent_vld[j] && ent_addr[i] == ent_addr[j]) dup = 1'b1;
      end
    end
  end

  // R1
  a_r1_unique_addr: assert property (@(posedge clk) disable iff (!rst_n) !dup);
  // R4
  a_r4_halt_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(fetch_valid && !halted));
  // R3
  a_r3_log_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    log_stb |-> $past(fetch_valid && !halted));
  // R5
  a_r5_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tmp_arm |=> tmp_armed);
  // R6
  a_r6_tmp_match_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !halted && tmp_armed && fetch_pc == tmp_addr) |=> halt_req);
  // R7
  a_r7_halt_entry_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(halted) && !tmp_arm) |=> !tmp_armed);
endmodule

bind bp_unit bp_unit_chk #(.AW(AW), .N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
  .halted(halted), .tmp_arm(tmp_arm), .tmp_armed(tmp_armed), .tmp_addr(tmp_addr),
  .halt_req(halt_req), .log_stb(log_stb), .ent_vld(ent_vld), .ent_addr(ent_addr)
);

// File: tb/sim_bp_unit.sv
`timescale 1ns/1ps
module sim_bp_unit;
  localparam int AW = 32;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_valid = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic [N-1:0]  cond_true = '1;
  logic          halted = 1'b0;
  logic          bp_wr_valid = 1'b0;
  logic          bp_wr_ready;
  logic [AW-1:0] bp_wr_addr = '0;
  logic          bp_wr_en = 1'b0, bp_wr_log = 1'b0, bp_wr_brk = 1'b0;
  logic          clr_valid = 1'b0;
  logic [AW-1:0] clr_addr = '0;
  logic          tmp_arm = 1'b0;
  logic [AW-1:0] tmp_base = '0;
  logic          tmp_plus4 = 1'b0;
  logic          halt_req, log_stb, tmp_armed;
  logic [AW-1:0] log_addr;
  logic [IW-1:0] log_idx;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  bp_unit u0 (.*);

  // behavioural reference model
  bit          mv [N];
  logic [31:0] ma [N];
  bit          me [N], ml [N], mb [N];
  bit          mtarm, mhq;
  logic [31:0] mta;
  bit          eh, el;
  logic [31:0] ela;
  int          eli;

  always @(posedge clk) begin : model
    bit th;
    int hi, wi, ci;
    cycles++;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin mv[i] = 0; ma[i] = 0; me[i] = 0; ml[i] = 0; mb[i] = 0; end
      mtarm = 0; mhq = 0; mta = 0; eh = 0; el = 0; ela = 0; eli = 0;
    end else begin
      eh = 0; el = 0;
      if (fetch_valid && !halted) begin
        th = mtarm && (fetch_pc == mta);
        hi = -1;
        for (int i = 0; i < N; i++)
          if (hi < 0 && mv[i] && ma[i] == fetch_pc && me[i] && cond_true[i]) hi = i;
        if (th) eh = 1;
        else if (hi >= 0) begin
          eh = mb[hi]; el = ml[hi];
          if (ml[hi]) begin ela = fetch_pc; eli = hi; end
        end
      end
      wi = -1;
      for (int i = 0; i < N; i++) if (wi < 0 && mv[i] && ma[i] == bp_wr_addr) wi = i;
      if (wi < 0) for (int i = 0; i < N; i++) if (wi < 0 && !mv[i]) wi = i;
      ci = -1;
      for (int i = 0; i < N; i++) if (ci < 0 && mv[i] && ma[i] == clr_addr) ci = i;
      if (clr_valid && ci >= 0) mv[ci] = 0;
      if (bp_wr_valid && wi >= 0) begin
        mv[wi] = 1; ma[wi] = bp_wr_addr; me[wi] = bp_wr_en; ml[wi] = bp_wr_log; mb[wi] = bp_wr_brk;
      end
      if (tmp_arm) begin mtarm = 1; mta = tmp_base + (tmp_plus4 ? 32'd4 : 32'd0); end
      else if (halted && !mhq) mtarm = 0;
      mhq = halted;
    end
  end

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_ready();
    bit any = 0;
    for (int i = 0; i < N; i++) if (!mv[i] || ma[i] == bp_wr_addr) any = 1;
    return any;
  endfunction

  // compare on every falling edge; inputs change 2 ns later
  always @(negedge clk) begin
    if (rst_n) begin
      cmp("R4 halt_req", {63'd0, halt_req}, {63'd0, eh});
      cmp("R3 log_stb", {63'd0, log_stb}, {63'd0, el});
      if (el) begin
        cmp("R3 log_addr", {32'd0, log_addr}, {32'd0, ela});
        cmp("R3 log_idx", {61'd0, log_idx}, 64'(eli));
      end
      cmp("R5 tmp_armed", {63'd0, tmp_armed}, {63'd0, mtarm});
      cmp("R1 bp_wr_ready", {63'd0, bp_wr_ready}, {63'd0, exp_ready()});
    end
  end

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin @(negedge clk); #2; end
  endtask

  task automatic wr(input logic [31:0] a, input bit en, input bit lg, input bit bk);
    bp_wr_valid = 1; bp_wr_addr = a; bp_wr_en = en; bp_wr_log = lg; bp_wr_brk = bk;
    tick(); bp_wr_valid = 0;
  endtask

  task automatic fetch(input logic [31:0] a);
    fetch_valid = 1; fetch_pc = a; tick(); fetch_valid = 0; tick();
  endtask

  task automatic arm(input logic [31:0] a, input bit p4);
    tmp_arm = 1; tmp_base = a; tmp_plus4 = p4; tick(); tmp_arm = 0;
  endtask

  task automatic clr(input logic [31:0] a);
    clr_valid = 1; clr_addr = a; tick(); clr_valid = 0;
  endtask

  initial begin : wdog
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [15:0] lf;
    tick(3);
    rst_n = 1;
    tick();
    // R9: reset state
    cmp("R9 halt_req", {63'd0, halt_req}, 64'd0);
    cmp("R9 log_stb", {63'd0, log_stb}, 64'd0);
    cmp("R9 tmp_armed", {63'd0, tmp_armed}, 64'd0);
    cmp("R9 bp_wr_ready", {63'd0, bp_wr_ready}, 64'd1);

    // R1: allocation lowest free; R2/R3 hits, log-only never halts
    wr(32'h100, 1, 0, 1);  // slot 0 break
    wr(32'h104, 1, 1, 0);  // slot 1 log only
    wr(32'h108, 1, 1, 1);  // slot 2 both
    wr(32'h10C, 0, 1, 1);  // slot 3 disabled
    fetch(32'h100); fetch(32'h104); fetch(32'h108); fetch(32'h10C); fetch(32'h110);
    // R2: condition low blocks
    cond_true = 8'b1111_1011; fetch(32'h108); cond_true = '1;
    // R1: update in place
    wr(32'h100, 1, 1, 0); fetch(32'h100);
    // R4: halted suppresses
    halted = 1; tick(); fetch(32'h108); halted = 0; tick();
    // R10: lookup same cycle as write sees old table
    fetch_valid = 1; fetch_pc = 32'h120; bp_wr_valid = 1; bp_wr_addr = 32'h120;
    bp_wr_en = 1; bp_wr_log = 1; bp_wr_brk = 1; tick();
    bp_wr_valid = 0; tick(); fetch_valid = 0; tick();
    // R1: fill table, back-pressure on new address
    wr(32'h124, 1, 0, 1); wr(32'h128, 1, 0, 1); wr(32'h12C, 1, 0, 1);
    bp_wr_valid = 1; bp_wr_addr = 32'h130; bp_wr_en = 1; bp_wr_log = 1; bp_wr_brk = 1;
    tick(2); bp_wr_valid = 0;
    fetch(32'h130);
    // R8: clear removes; absent clear harmless; write beats clear
    clr(32'h124); fetch(32'h124); clr(32'h999);
    clr_valid = 1; clr_addr = 32'h128; bp_wr_valid = 1; bp_wr_addr = 32'h128;
    bp_wr_en = 1; bp_wr_log = 1; bp_wr_brk = 0; tick();
    clr_valid = 0; bp_wr_valid = 0; fetch(32'h128);
    // R5/R6: temporary over a regular log entry, plus4 arming, overwrite
    arm(32'h104, 0); fetch(32'h104);
    halted = 1; tick(2); halted = 0; tick();  // R7 disarm on halt entry
    fetch(32'h104);                           // R6 regular entry intact
    arm(32'h200, 1); arm(32'h300, 1); fetch(32'h204); fetch(32'h304);
    // R7: arm in the cycle halted rises wins
    tick(); halted = 1; tmp_arm = 1; tmp_base = 32'h400; tmp_plus4 = 0; tick();
    tmp_arm = 0; tick(); halted = 0; tick(); fetch(32'h400);
    halted = 1; tick(); halted = 0; tick();

    // mixed traffic
    lf = 16'hACE1;
    for (int c = 0; c < 1500; c++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      fetch_valid = lf[0]; fetch_pc = 32'h100 + {28'd0, lf[4:2], 2'b00};
      bp_wr_valid = lf[5] & lf[6]; bp_wr_addr = 32'h100 + {28'd0, lf[9:7], 2'b00};
      bp_wr_en = lf[10]; bp_wr_log = lf[11]; bp_wr_brk = lf[12];
      clr_valid = lf[13] & lf[5]; clr_addr = 32'h100 + {28'd0, lf[15:14], lf[1], 2'b00};
      tmp_arm = (lf[15:12] == 4'h3); tmp_base = 32'h100 + {28'd0, lf[3:1], 2'b00};
      tmp_plus4 = lf[8];
      halted = (lf[11:9] == 3'd7);
      cond_true = {lf[7:0]} | 8'h55;
      tick();
    end
    fetch_valid = 0; bp_wr_valid = 0; clr_valid = 0; tmp_arm = 0; halted = 0;
    tick(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule